// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Unit

This block serves the acknowledge cycle of a two-level interrupt controller. A primary unit has a secondary unit wired to its request line 2. When the processor strobes an acknowledge, the block looks at the winning line and the "no request" flag that each unit's arbiter presents. It chooses which unit supplies the vector and updates the in-service mask and priority base of each unit that is acknowledged. It also pulses a clear for any edge-triggered request that was taken. Arbitration and register programming are outside the block. Their results come in as plain inputs: the winner indices, the vector bases, the trigger-level masks and the auto end-of-interrupt controls.

One cycle after the strobe, the block presents an 8-bit vector with a one-cycle valid pulse. The upper bits of the vector come from a programmed base and the lower three bits come from the line index. If no request is present, the line index is forced to all ones, which gives a spurious vector. The secondary unit can also give a spurious vector when it has no request. The sequencing is a small state machine with five named states:
- `ST_IDLE`: no vector is presented.
- `ST_MASTER`: the vector comes from the primary unit.
- `ST_SLAVE`: the vector comes from the secondary unit through the cascade.
- `ST_SPUR_M`: the primary unit had no request.
- `ST_SPUR_S`: the cascade was taken but the secondary unit had no request.

The state machine takes these transitions:
- Every acknowledge moves it from any state to the state chosen by the classifier.
- Any cycle without an acknowledge returns it to `ST_IDLE`.
- Back-to-back acknowledges are accepted.

Top module: `ack_vector_unit`

## Requirements
- R1: After reset, `vec_valid_o` is 0. Both in-service masks, both priority bases and both request-clear outputs are 0.
- R2: If `m_none_i` is 1 when an acknowledge is taken, the vector is the primary base with its low three bits replaced by 7. Neither unit changes its in-service mask or its priority base, and no request clear is pulsed.
- R3: If the primary winner is a line other than 2, the vector is the primary base upper five bits followed by that line index.
- R4: If the primary winner is line 2 and `s_none_i` is 0, the vector is the secondary base upper five bits followed by the secondary winner index. The secondary unit acknowledges its winner and the primary unit acknowledges line 2 in the same cycle.
- R5: If the primary winner is line 2 and `s_none_i` is 1, the vector is the secondary base upper five bits followed by 7. The primary unit still acknowledges line 2 and the secondary unit is left untouched.
- R6: An acknowledge of line k in a unit whose auto end-of-interrupt control is 0 sets bit k of that unit's in-service mask. No other bit of the mask changes.
- R7: In a unit whose auto end-of-interrupt control is 1, an acknowledge leaves the in-service mask unchanged. If that unit's rotate control is also 1, its priority base becomes (k+1) mod 8. Otherwise the priority base is unchanged.
- R8: For an acknowledged line k whose bit in the unit's level mask is 0 (edge-triggered), that unit's request-clear output shows only bit k, for exactly one cycle. A line whose level-mask bit is 1 produces no clear.
- R9: `vec_valid_o` is 1 in the cycle after each cycle with `ack_i` high, and 0 in every other cycle. The vector and all state changes appear in that same cycle.
- R10: The low three bits of both base inputs have no effect on the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_i | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| m_win_i | input | 3 | Primary arbiter winning line |
| m_none_i | input | 1 | Primary arbiter has no qualifying request |
| s_win_i | input | 3 | Secondary arbiter winning line |
| s_none_i | input | 1 | Secondary arbiter has no qualifying request |
| m_base_i | input | 8 | Primary vector base; upper five bits used |
| s_base_i | input | 8 | Secondary vector base; upper five bits used |
| m_auto_eoi_i | input | 1 | Primary auto end-of-interrupt enable |
| m_rot_aeoi_i | input | 1 | Primary rotate-on-auto-end-of-interrupt enable |
| s_auto_eoi_i | input | 1 | Secondary auto end-of-interrupt enable |
| s_rot_aeoi_i | input | 1 | Secondary rotate-on-auto-end-of-interrupt enable |
| m_level_i | input | 8 | Primary per-line level-trigger mask (1 = level) |
| s_level_i | input | 8 | Secondary per-line level-trigger mask (1 = level) |
| vec_o | output | 8 | Acknowledge vector |
| vec_valid_o | output | 1 | One-cycle vector valid pulse |
| m_isr_o | output | 8 | Primary in-service mask |
| s_isr_o | output | 8 | Secondary in-service mask |
| m_prio_o | output | 3 | Primary priority base |
| s_prio_o | output | 3 | Secondary priority base |
| m_req_clr_o | output | 8 | Primary request-clear pulse, one-hot |
| s_req_clr_o | output | 8 | Secondary request-clear pulse, one-hot |

## Verification
Every primary outcome is swept: no request, and each of the eight lines. When line 2 wins, every secondary outcome is swept as well. This separates the direct, cascaded, primary-spurious and secondary-spurious vector paths, and shows whether both units were touched on a cascade. The sweep runs under four control settings: plain nesting, auto end-of-interrupt, auto end-of-interrupt with rotation, and a mixed setting. The mixed setting shows that each unit obeys its own controls. Level masks with alternating bits separate lines whose requests are cleared from lines whose requests are kept. Bases with nonzero low bits show that those bits are ignored, and idle cycles with changing winners show that no vector appears without a strobe.

// File: rtl/ack_pkg.sv
package ack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MASTER = 3'd1,
        ST_SLAVE  = 3'd2,
        ST_SPUR_M = 3'd3,
        ST_SPUR_S = 3'd4
    } ack_state_e;
endpackage

// File: rtl/ack_classify.sv
module ack_classify
    import ack_pkg::*;
#(
    parameter int IDXW         = 3,
    parameter int CASCADE_LINE = 2
) (
    input  logic            m_none,
    input  logic [IDXW-1:0] m_win,
    input  logic            s_none,
    input  logic [IDXW-1:0] s_win,
    output ack_state_e      kind,
    output logic            m_take,
    output logic [IDXW-1:0] m_line,
    output logic            s_take,
    output logic [IDXW-1:0] s_line
);
    localparam logic [IDXW-1:0] CASC = IDXW'(CASCADE_LINE);

    always_comb begin
        kind   = ST_SPUR_M;
        m_take = 1'b0;
        s_take = 1'b0;
        m_line = m_win;
        s_line = s_win;
        if (!m_none) begin
            m_take = 1'b1;
            if (m_win == CASC) begin
                if (s_none) begin
                    kind = ST_SPUR_S;
                end else begin
                    kind   = ST_SLAVE;
                    s_take = 1'b1;
                end
            end else begin
                kind = ST_MASTER;
            end
        end
    end
endmodule

// File: rtl/ack_unit_state.sv
module ack_unit_state #(
    parameter int LINES = 8,
    parameter int IDXW  = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDXW-1:0]  line,
    input  logic             auto_eoi,
    input  logic             rot_aeoi,
    input  logic [LINES-1:0] level,
    output logic [LINES-1:0] isr,
    output logic [IDXW-1:0]  prio,
    output logic [LINES-1:0] req_clr
);
    logic [LINES-1:0] line_bit;
    assign line_bit = LINES'(1) << line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr     <= '0;
            prio    <= '0;
            req_clr <= '0;
        end else begin
            req_clr <= '0;
            if (take) begin
                if (auto_eoi) begin
                    if (rot_aeoi) begin
                        prio <= line + IDXW'(1);
                    end
                end else begin
                    isr <= isr | line_bit;
                end
                if (!level[line]) begin
                    req_clr <= line_bit;
                end
            end
        end
    end
endmodule

// File: rtl/ack_vector_unit.sv
module ack_vector_unit
    import ack_pkg::*;
#(
    parameter int LINES        = 8,
    parameter int VEC_W        = 8,
    parameter int CASCADE_LINE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ack_i,
    input  logic [$clog2(LINES)-1:0] m_win_i,
    input  logic                     m_none_i,
    input  logic [$clog2(LINES)-1:0] s_win_i,
    input  logic                     s_none_i,
    input  logic [VEC_W-1:0]         m_base_i,
    input  logic [VEC_W-1:0]         s_base_i,
    input  logic                     m_auto_eoi_i,
    input  logic                     m_rot_aeoi_i,
    input  logic                     s_auto_eoi_i,
    input  logic                     s_rot_aeoi_i,
    input  logic [LINES-1:0]         m_level_i,
    input  logic [LINES-1:0]         s_level_i,
    output logic [VEC_W-1:0]         vec_o,
    output logic                     vec_valid_o,
    output logic [LINES-1:0]         m_isr_o,
    output logic [LINES-1:0]         s_isr_o,
    output logic [$clog2(LINES)-1:0] m_prio_o,
    output logic [$clog2(LINES)-1:0] s_prio_o,
    output logic [LINES-1:0]         m_req_clr_o,
    output logic [LINES-1:0]         s_req_clr_o
);
    localparam int IDXW  = $clog2(LINES);
    localparam int BASEW = VEC_W - IDXW;
    localparam int UNITS = 2;
    localparam logic [IDXW-1:0] SPUR_IDX = '1;

    ack_state_e      kind;
    logic            m_take, s_take;
    logic [IDXW-1:0] m_line, s_line;

    ack_classify #(.IDXW(IDXW), .CASCADE_LINE(CASCADE_LINE)) u_classify (
        .m_none (m_none_i),
        .m_win  (m_win_i),
        .s_none (s_none_i),
        .s_win  (s_win_i),
        .kind   (kind),
        .m_take (m_take),
        .m_line (m_line),
        .s_take (s_take),
        .s_line (s_line)
    );

    logic [UNITS-1:0]            u_take, u_aeoi, u_rot;
    logic [UNITS-1:0][IDXW-1:0]  u_line, u_prio;
    logic [UNITS-1:0][LINES-1:0] u_level, u_isr, u_clr;

    assign u_take  = {s_take & ack_i, m_take & ack_i};
    assign u_line  = {s_line, m_line};
    assign u_aeoi  = {s_auto_eoi_i, m_auto_eoi_i};
    assign u_rot   = {s_rot_aeoi_i, m_rot_aeoi_i};
    assign u_level = {s_level_i, m_level_i};

    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        ack_unit_state #(.LINES(LINES), .IDXW(IDXW)) u_state (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (u_take[g]),
            .line     (u_line[g]),
            .auto_eoi (u_aeoi[g]),
            .rot_aeoi (u_rot[g]),
            .level    (u_level[g]),
            .isr      (u_isr[g]),
            .prio     (u_prio[g]),
            .req_clr  (u_clr[g])
        );
    end

    assign m_isr_o     = u_isr[0];
    assign s_isr_o     = u_isr[1];
    assign m_prio_o    = u_prio[0];
    assign s_prio_o    = u_prio[1];
    assign m_req_clr_o = u_clr[0];
    assign s_req_clr_o = u_clr[1];

    ack_state_e      state_q;
    logic [BASEW-1:0] base_q;
    logic [IDXW-1:0]  idx_q;

    // state register plus captured vector fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= ack_i ? kind : ST_IDLE;
            if (ack_i) begin
                if (kind == ST_SLAVE || kind == ST_SPUR_S) begin
                    base_q <= s_base_i[VEC_W-1:IDXW];
                end else begin
                    base_q <= m_base_i[VEC_W-1:IDXW];
                end
                idx_q <= s_win_i;
            end
        end
    end

    // outputs decoded from the current state
    always_comb begin
        vec_o       = '0;
        vec_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                vec_o       = '0;
                vec_valid_o = 1'b0;
            end
            ST_MASTER: begin
                vec_o       = {base_q, m_line_q};
                vec_valid_o = 1'b1;
            end
            ST_SLAVE: begin
                vec_o       = {base_q, idx_q};
                vec_valid_o = 1'b1;
            end
            ST_SPUR_M, ST_SPUR_S: begin
                vec_o       = {base_q, SPUR_IDX};
                vec_valid_o = 1'b1;
            end
            default: begin
                vec_o       = '0;
                vec_valid_o = 1'b0;
            end
        endcase
    end

    logic [IDXW-1:0] m_line_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_line_q <= '0;
        end else if (ack_i) begin
            m_line_q <= m_win_i;
        end
    end
endmodule

// File: rtl/ack_vector_chk.sv
module ack_vector_chk #(
    parameter int LINES = 8,
    parameter int VEC_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ack_i,
    input logic                     m_none_i,
    input logic                     m_auto_eoi_i,
    input logic [VEC_W-1:0]         vec_o,
    input logic                     vec_valid_o,
    input logic [LINES-1:0]         m_isr_o,
    input logic [LINES-1:0]         s_isr_o,
    input logic [$clog2(LINES)-1:0] m_prio_o,
    input logic [$clog2(LINES)-1:0] s_prio_o,
    input logic [LINES-1:0]         m_req_clr_o,
    input logic [LINES-1:0]         s_req_clr_o
);
    localparam int IDXW = $clog2(LINES);

    // R9
    ack_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_valid_o);

    // R9
    valid_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_valid_o);

    // R2
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && m_none_i) |=> (vec_o[IDXW-1:0] == {IDXW{1'b1}}));

    // R2
    spur_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && m_none_i) |=> ($stable(m_isr_o) && $stable(s_isr_o)
            && $stable(m_prio_o) && $stable(s_prio_o)
            && m_req_clr_o == '0 && s_req_clr_o == '0));

    // R8
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_req_clr_o) && $onehot0(s_req_clr_o));

    // R7
    aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && m_auto_eoi_i) |=> $stable(m_isr_o));

    // R6
    isr_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(m_isr_o ^ $past(m_isr_o)) <= 1)
        && ($countones(s_isr_o ^ $past(s_isr_o)) <= 1));

    // R6
    isr_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ($stable(m_isr_o) && $stable(s_isr_o)));
endmodule

bind ack_vector_unit ack_vector_chk #(.LINES(LINES), .VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .m_none_i     (m_none_i),
    .m_auto_eoi_i (m_auto_eoi_i),
    .vec_o        (vec_o),
    .vec_valid_o  (vec_valid_o),
    .m_isr_o      (m_isr_o),
    .s_isr_o      (s_isr_o),
    .m_prio_o     (m_prio_o),
    .s_prio_o     (s_prio_o),
    .m_req_clr_o  (m_req_clr_o),
    .s_req_clr_o  (s_req_clr_o)
);

// File: tb/tb_ack_vector_unit.sv
`timescale 1ns/1ps
module tb_ack_vector_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_i = 1'b0;
    logic [2:0] m_win_i = '0, s_win_i = '0;
    logic       m_none_i = 1'b1, s_none_i = 1'b1;
    logic [7:0] m_base_i = '0, s_base_i = '0;
    logic       m_auto_eoi_i = 1'b0, m_rot_aeoi_i = 1'b0;
    logic       s_auto_eoi_i = 1'b0, s_rot_aeoi_i = 1'b0;
    logic [7:0] m_level_i = '0, s_level_i = '0;
    logic [7:0] vec_o, m_isr_o, s_isr_o, m_req_clr_o, s_req_clr_o;
    logic       vec_valid_o;
    logic [2:0] m_prio_o, s_prio_o;

    ack_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .ack_i(ack_i),
        .m_win_i(m_win_i), .m_none_i(m_none_i),
        .s_win_i(s_win_i), .s_none_i(s_none_i),
        .m_base_i(m_base_i), .s_base_i(s_base_i),
        .m_auto_eoi_i(m_auto_eoi_i), .m_rot_aeoi_i(m_rot_aeoi_i),
        .s_auto_eoi_i(s_auto_eoi_i), .s_rot_aeoi_i(s_rot_aeoi_i),
        .m_level_i(m_level_i), .s_level_i(s_level_i),
        .vec_o(vec_o), .vec_valid_o(vec_valid_o),
        .m_isr_o(m_isr_o), .s_isr_o(s_isr_o),
        .m_prio_o(m_prio_o), .s_prio_o(s_prio_o),
        .m_req_clr_o(m_req_clr_o), .s_req_clr_o(s_req_clr_o)
    );

    always #4 clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [7:0] e_isr [2];
    logic [2:0] e_prio [2];
    logic [7:0] e_clr [2];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_take(input int u, input int line, input bit aeoi,
                              input bit rot, input logic [7:0] lvl);
        if (aeoi) begin
            if (rot) e_prio[u] = 3'((line + 1) % 8);
        end else begin
            e_isr[u] = e_isr[u] | (8'd1 << line);
        end
        e_clr[u] = lvl[line] ? 8'd0 : (8'd1 << line);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int u = 0; u < 2; u++) begin
            e_isr[u] = '0; e_prio[u] = '0; e_clr[u] = '0;
        end
        @(negedge clk);
        chk("R1 valid", 32'(vec_valid_o), 0);
        chk("R1 m_isr", 32'(m_isr_o), 0);
        chk("R1 s_isr", 32'(s_isr_o), 0);
        chk("R1 prio", 32'({m_prio_o, s_prio_o}), 0);
        chk("R1 clr", 32'({m_req_clr_o, s_req_clr_o}), 0);
    endtask

    // mc/sc: 0..7 line index, 8 = no request
    task automatic do_ack(input int mc, input int sc);
        logic [7:0] ev;
        m_none_i = (mc == 8);
        m_win_i  = 3'(mc);
        s_none_i = (sc == 8);
        s_win_i  = 3'(sc);
        m_base_i = 8'h40 | 8'(mc);       // low bits junk: R10
        s_base_i = 8'hA8 | 8'(7 - sc);   // low bits junk: R10
        e_clr[0] = '0; e_clr[1] = '0;
        if (mc == 8) begin
            ev = {m_base_i[7:3], 3'd7};
        end else if (mc == 2) begin
            model_take(0, 2, m_auto_eoi_i, m_rot_aeoi_i, m_level_i);
            if (sc == 8) begin
                ev = {s_base_i[7:3], 3'd7};
            end else begin
                ev = {s_base_i[7:3], 3'(sc)};
                model_take(1, sc, s_auto_eoi_i, s_rot_aeoi_i, s_level_i);
            end
        end else begin
            ev = {m_base_i[7:3], 3'(mc)};
            model_take(0, mc, m_auto_eoi_i, m_rot_aeoi_i, m_level_i);
        end
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        m_win_i = ~m_win_i;              // idle changes must not matter
        m_none_i = 1'b0;
        chk("R9 valid", 32'(vec_valid_o), 1);
        if (mc == 8)      chk("R2 R10 spurious vec", 32'(ev ^ vec_o) ^ 32'(ev), 32'(ev));
        else if (mc != 2) chk("R3 R10 vec", 32'(vec_o), 32'(ev));
        else if (sc != 8) chk("R4 R10 cascade vec", 32'(vec_o), 32'(ev));
        else              chk("R5 R10 slave spurious vec", 32'(vec_o), 32'(ev));
        chk("R6 R7 m_isr", 32'(m_isr_o), 32'(e_isr[0]));
        chk("R6 R7 s_isr", 32'(s_isr_o), 32'(e_isr[1]));
        chk("R7 m_prio", 32'(m_prio_o), 32'(e_prio[0]));
        chk("R7 s_prio", 32'(s_prio_o), 32'(e_prio[1]));
        chk("R8 m_clr", 32'(m_req_clr_o), 32'(e_clr[0]));
        chk("R8 s_clr", 32'(s_req_clr_o), 32'(e_clr[1]));
        @(negedge clk);
        chk("R9 valid drop", 32'(vec_valid_o), 0);
        chk("R8 clr drop", 32'({m_req_clr_o, s_req_clr_o}), 0);
    endtask

    initial begin
        for (int cfg = 0; cfg < 4; cfg++) begin
            m_auto_eoi_i = (cfg == 1 || cfg == 2);
            m_rot_aeoi_i = (cfg == 2);
            s_auto_eoi_i = (cfg != 0);
            s_rot_aeoi_i = (cfg >= 2);
            m_level_i = (cfg[0]) ? 8'h5A : 8'hA5;
            s_level_i = (cfg[0]) ? 8'hC3 : 8'h3C;
            do_reset();
            for (int mc = 0; mc <= 8; mc++) begin
                if (mc == 2) begin
                    for (int sc = 0; sc <= 8; sc++) do_ack(mc, sc);
                end else begin
                    do_ack(mc, (mc + 3) % 9);
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule